// File: doc/BRIEF.md
# Wakeup Pin Event Detector

This block watches five external wakeup pins and records a wakeup event per pin. Each pin has an enable, a polarity select and a two-bit pull selection held in a configuration register. An enabled pin raises a sticky flag when it moves to its active level. The active level is high for polarity 0 and low for polarity 1. A pin also raises its flag when it is already at its active level at the moment it is enabled or its polarity changes. All flags are ORed into a registered wakeup request for the low-power sequencer.

Software reaches the block over a simple register bus. The bus has a byte address, 32-bit write data, a write strobe and combinational read data. Flags are read from a status register. Each flag is dropped by writing 1 to its bit in a write-only clear register. The pins pass through a two-flop synchronizer inside the block. The pull selection is driven out to the pad logic unchanged.

Top module: `wakeup_pin_detector`

## Requirements
- R1: After reset, the status register, the configuration register, `pull_sel` and `wake_req` all read 0.
- R2: The configuration register sits at byte address 0x48. Bits 4:0 are the pin enables and bits 12:8 the pin polarities. Pin i has a 2-bit pull field at bits 17+2i:16+2i, with 00 none, 01 pull-up, 10 pull-down and 11 reserved, each stored as written. All other bits read 0, and `pull_sel` carries bits 25:16.
- R3: With polarity 0, a low-to-high change on an enabled pin sets its flag. The flag becomes visible after the third rising clock edge, counting from the first edge that samples the new pin level.
- R4: With polarity 1, a high-to-low change on an enabled pin sets its flag.
- R5: Enabling a pin that already sits at its active level sets its flag on the first clock edge after the edge that performs the write.
- R6: Changing the polarity of an enabled pin so that its present level becomes active sets its flag on the first edge after the write. A change that makes the level inactive sets nothing.
- R7: A disabled pin never sets its flag, whatever its level changes.
- R8: Flags read at bits 4:0 of byte address 0x44. They stay set until reset or an explicit clear. Writes to 0x44 or 0x48 do not clear them.
- R9: Writing 1 to bit i of byte address 0x40 clears flag i on that edge, and 0 bits have no effect. Address 0x40 always reads 0.
- R10: When a clear and a new event hit the same pin in the same cycle, the flag ends up set.
- R11: `wake_req` is the OR of all flags, registered, so it follows the flags one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| pin_i | input | 5 | Asynchronous wakeup pin levels |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pull_sel | output | 10 | Per-pin 2-bit pull selection to the pads |
| wake_req | output | 1 | Registered OR of all wakeup flags |

## Verification
A vector table first sets the pins to a starting level with every pin disabled. It then writes a configuration and moves the pins to a final level. The vectors mix rising, falling, enable-while-active, held-level, partially enabled and fully disabled patterns, which separates edge detection from level arming and masks from polarity. Directed tests then pin down the latency of each path to the clock edge. They also cover the polarity flip on a pin held at one level, and a clear that lands in the same cycle as an event. Finally they check that writes to the status and configuration addresses leave the flags alone.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  // Register byte addresses; software and neighbouring firmware decode these.
  localparam logic [7:0] ADDR_CLR  = 8'h40;
  localparam logic [7:0] ADDR_STAT = 8'h44;
  localparam logic [7:0] ADDR_CFG  = 8'h48;

  // Field base positions inside the configuration word.
  localparam int EN_LSB   = 0;
  localparam int POL_LSB  = 8;
  localparam int PULL_LSB = 16;
  localparam int PULL_W   = 2;

  // Upper bound on pins imposed by the field layout above.
  localparam int MAX_PINS = 8;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_UP   = 2'b01,
    PULL_DOWN = 2'b10,
    PULL_RSVD = 2'b11
  } pull_e;
endpackage

// File: rtl/wkp_pin_sync.sv
module wkp_pin_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
          stage_q[0] <= d;
          for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wkp_reg_file.sv
module wkp_reg_file
  import wkp_pkg::*;
#(
  parameter int NUM_PINS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [7:0]                 addr,
  input  logic [31:0]                wdata,
  input  logic                       we,
  input  logic [NUM_PINS-1:0]        flags,
  output logic [NUM_PINS-1:0]        en,
  output logic [NUM_PINS-1:0]        pol,
  output logic [PULL_W*NUM_PINS-1:0] pull,
  output logic [NUM_PINS-1:0]        clr,
  output logic [31:0]                rdata
);
  localparam int PULL_BITS = PULL_W * NUM_PINS;

  logic                 cfg_we;
  logic [NUM_PINS-1:0]  en_d, en_q, pol_d, pol_q;
  logic [PULL_BITS-1:0] pull_d, pull_q;
  logic [31:0]          cfg_word;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata;
  assign cfg_we = we && (addr == ADDR_CFG);

  // Next-state of the configuration fields.
  always_comb begin
    en_d   = en_q;
    pol_d  = pol_q;
    pull_d = pull_q;
    if (cfg_we) begin
      en_d   = wdata[EN_LSB +: NUM_PINS];
      pol_d  = wdata[POL_LSB +: NUM_PINS];
      pull_d = wdata[PULL_LSB +: PULL_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      pull_q <= '0;
    end else if (cfg_we) begin
      en_q   <= en_d;
      pol_q  <= pol_d;
      pull_q <= pull_d;
    end
  end

  // Clear strobes exist for one cycle only; nothing is stored.
  assign clr = (we && (addr == ADDR_CLR)) ? wdata[NUM_PINS-1:0] : '0;

  always_comb begin
    cfg_word = '0;
    cfg_word[EN_LSB +: NUM_PINS]    = en_q;
    cfg_word[POL_LSB +: NUM_PINS]   = pol_q;
    cfg_word[PULL_LSB +: PULL_BITS] = pull_q;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_STAT: rdata[NUM_PINS-1:0] = flags;
      ADDR_CFG:  rdata = cfg_word;
      default:   rdata = '0;
    endcase
  end

  assign en   = en_q;
  assign pol  = pol_q;
  assign pull = pull_q;

  // R2: configuration only moves on a write to its own address.
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(en_q) && $stable(pol_q) && $stable(pull_q)));
  // R9: the clear address reads back as zero.
  p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_CLR) |-> (rdata == '0));
endmodule

// File: rtl/wkp_edge_detect.sv
module wkp_edge_detect #(
  parameter int NUM_PINS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_s,
  input  logic [NUM_PINS-1:0] en,
  input  logic [NUM_PINS-1:0] pol,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] flags,
  output logic                wake_req
);
  logic [NUM_PINS-1:0] act_now, act_q, evt;
  logic [NUM_PINS-1:0] flag_d, flag_q;
  logic                flag_upd;
  logic                req_d, req_q;

  // Qualified active level: one rule covers edges, enabling while active and
  // polarity flips, since each one turns this term from 0 to 1.
  assign act_now  = en & (pin_s ^ pol);
  assign evt      = act_now & ~act_q;
  assign flag_d   = (flag_q & ~clr) | evt;
  assign flag_upd = |(evt | clr);
  assign req_d    = |flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= '0;
    else if (flag_upd) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign flags    = flag_q;
  assign wake_req = req_q;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
      // R7: a flag only rises when its pin was enabled.
      p_flag_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[i]) |-> $past(en[i]));
      // R9: a clear without a coinciding event drops the flag.
      p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !evt[i]) |=> !flag_q[i]);
      // R10: an event always leaves the flag set.
      p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> flag_q[i]);
      // R8: a set flag persists until cleared.
      p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[i] && !clr[i]) |=> flag_q[i]);
    end
  endgenerate

  // R11: request follows the flag OR one edge later.
  p_req_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_q) |=> req_q);
  p_req_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|flag_q) |=> !req_q);
endmodule

// File: rtl/wakeup_pin_detector.sv
module wakeup_pin_detector
  import wkp_pkg::*;
#(
  parameter int NUM_PINS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pin_i,
  input  logic [7:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  input  logic                       bus_we,
  output logic [31:0]                bus_rdata,
  output logic [PULL_W*NUM_PINS-1:0] pull_sel,
  output logic                       wake_req
);
  logic [NUM_PINS-1:0] pin_s, en, pol, clr, flags;

  wkp_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (pin_i),
    .q (pin_s)
  );

  wkp_reg_file #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .we    (bus_we),
    .flags (flags),
    .en    (en),
    .pol   (pol),
    .pull  (pull_sel),
    .clr   (clr),
    .rdata (bus_rdata)
  );

  wkp_edge_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (pin_s),
    .en       (en),
    .pol      (pol),
    .clr      (clr),
    .flags    (flags),
    .wake_req (wake_req)
  );
endmodule

// File: tb/wakeup_pin_detector_test.sv
`timescale 1ns/1ps
module wakeup_pin_detector_test;
  localparam logic [7:0] A_CLR  = 8'h40;
  localparam logic [7:0] A_STAT = 8'h44;
  localparam logic [7:0] A_CFG  = 8'h48;
  localparam logic [31:0] CFG_MASK = 32'h03FF_1F1F;

  // {pre pins, enable, polarity, post pins, expected flags}
  localparam int NVEC = 10;
  localparam logic [24:0] VEC [NVEC] = '{
    {5'b00000, 5'b11111, 5'b00000, 5'b11111, 5'b11111},  // R3 rising all
    {5'b11111, 5'b11111, 5'b11111, 5'b00000, 5'b11111},  // R4 falling all
    {5'b00000, 5'b00101, 5'b00000, 5'b11111, 5'b00101},  // R7 partial enable
    {5'b11111, 5'b11111, 5'b00000, 5'b11111, 5'b11111},  // R5 already high
    {5'b01010, 5'b11111, 5'b00000, 5'b01010, 5'b01010},  // R5 some high
    {5'b00000, 5'b00000, 5'b00000, 5'b11111, 5'b00000},  // R7 none enabled
    {5'b11111, 5'b11111, 5'b11111, 5'b11111, 5'b00000},  // R4 held inactive
    {5'b10101, 5'b11111, 5'b00000, 5'b00000, 5'b10101},  // R5 then falls
    {5'b00000, 5'b11111, 5'b01010, 5'b01010, 5'b01010},  // R4 R5 mixed pol
    {5'b00000, 5'b10000, 5'b00000, 5'b10000, 5'b10000}   // R3 single pin
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  pin_i;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [9:0]  pull_sel;
  logic        wake_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  wakeup_pin_detector uut (
    .clk (clk), .rst_n (rst_n), .pin_i (pin_i),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_we (bus_we),
    .bus_rdata (bus_rdata), .pull_sel (pull_sel), .wake_req (wake_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; pin_i = '0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    bus_read(A_STAT, rd); check("R1 status", rd, 32'h0);
    bus_read(A_CFG, rd);  check("R1 config", rd, 32'h0);
    check("R1 pull_sel", {22'h0, pull_sel}, 32'h0);
    check("R1 wake_req", {31'h0, wake_req}, 32'h0);

    // R2: field layout and read-back
    bus_write(A_CFG, 32'hFFFF_FFFF);
    bus_read(A_CFG, rd); check("R2 all ones", rd, 32'hFFFF_FFFF & CFG_MASK);
    check("R2 pull_sel ones", {22'h0, pull_sel}, 32'h3FF);
    bus_write(A_CFG, 32'h0249_0A05);
    bus_read(A_CFG, rd); check("R2 pattern", rd, 32'h0249_0A05 & CFG_MASK);
    check("R2 pull_sel pattern", {22'h0, pull_sel}, 32'h249);
    bus_write(A_CFG, 32'h0);
    bus_write(A_CLR, 32'h1F);
    idle(2);

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0] pre, en, pol, post, exp;
      {pre, en, pol, post, exp} = VEC[v];
      bus_write(A_CFG, 32'h0);
      pin_i = pre;
      idle(4);
      bus_write(A_CLR, 32'h1F);
      bus_write(A_CFG, {19'h0, pol, 3'h0, en});
      idle(4);
      pin_i = post;
      idle(5);
      bus_read(A_STAT, rd);
      check($sformatf("R3/R4/R5/R7 vector %0d flags", v), rd, {27'h0, exp});
      check($sformatf("R11 vector %0d wake_req", v), {31'h0, wake_req}, {31'h0, |exp});
    end

    // R3 latency and R11 request delay
    bus_write(A_CFG, 32'h0);
    pin_i = '0;
    idle(4);
    bus_write(A_CLR, 32'h1F);
    bus_write(A_CFG, 32'h0000_0001);
    idle(3);
    bus_addr = A_STAT;
    @(negedge clk); pin_i[0] = 1'b1;
    @(negedge clk); #2 check("R3 latency edge1", bus_rdata, 32'h0);
    @(negedge clk); #2 check("R3 latency edge2", bus_rdata, 32'h0);
    @(negedge clk); #2 check("R3 latency edge3", bus_rdata, 32'h1);
    check("R11 req lags flag", {31'h0, wake_req}, 32'h0);
    @(negedge clk); #2 check("R11 req follows", {31'h0, wake_req}, 32'h1);

    // R10: clear coincides with a new event on a set flag
    pin_i[0] = 1'b0;
    idle(5);
    @(negedge clk); pin_i[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = A_CLR; bus_wdata = 32'h1; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0; bus_addr = A_STAT;
    #2 check("R10 event beats clear", bus_rdata, 32'h1);

    // R8 and R9: stickiness and clear behaviour
    pin_i[0] = 1'b0;
    idle(5);
    bus_write(A_STAT, 32'h1F);
    bus_read(A_STAT, rd); check("R8 status write ignored", rd, 32'h1);
    bus_write(A_CFG, 32'h0000_0001);
    bus_read(A_STAT, rd); check("R8 config write ignored", rd, 32'h1);
    bus_write(A_CLR, 32'h1E);
    bus_read(A_STAT, rd); check("R9 zero bit no effect", rd, 32'h1);
    bus_read(A_CLR, rd);  check("R9 clear reads zero", rd, 32'h0);
    bus_write(A_CLR, 32'h1);
    bus_addr = A_STAT;
    #2 check("R9 clear drops flag", bus_rdata, 32'h0);
    check("R11 req still high", {31'h0, wake_req}, 32'h1);
    @(negedge clk); #2 check("R11 req drops", {31'h0, wake_req}, 32'h0);

    // R6: polarity flip on an enabled pin held low
    bus_write(A_CFG, 32'h0);
    pin_i = '0;
    idle(4);
    bus_write(A_CLR, 32'h1F);
    bus_write(A_CFG, 32'h0000_0004);
    idle(3);
    bus_read(A_STAT, rd); check("R6 inactive before flip", rd, 32'h0);
    bus_write(A_CFG, 32'h0000_0404);
    bus_addr = A_STAT;
    #2 check("R6 not yet", bus_rdata, 32'h0);
    @(negedge clk); #2 check("R6 flip sets flag", bus_rdata, 32'h4);
    bus_write(A_CLR, 32'h1F);
    bus_write(A_CFG, 32'h0000_0004);
    idle(3);
    bus_read(A_STAT, rd); check("R6 flip to inactive", rd, 32'h0);

    // R5: enable latency on a pin already high
    bus_write(A_CFG, 32'h0);
    pin_i = 5'b00010;
    idle(4);
    bus_write(A_CLR, 32'h1F);
    bus_write(A_CFG, 32'h0000_0002);
    bus_addr = A_STAT;
    #2 check("R5 not yet", bus_rdata, 32'h0);
    @(negedge clk); #2 check("R5 enable while active", bus_rdata, 32'h2);

    // R7: disabled pins toggled repeatedly
    bus_write(A_CFG, 32'h0000_1F00);
    bus_write(A_CLR, 32'h1F);
    for (int k = 0; k < 6; k++) begin
      pin_i = (k % 2 == 0) ? 5'b11111 : 5'b00000;
      idle(4);
    end
    bus_read(A_STAT, rd); check("R7 disabled toggles", rd, 32'h0);
    check("R7 no request", {31'h0, wake_req}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule